// File: doc/BRIEF.md
# Tag Array with Reserved Lines

This block is the tag store of a set-associative, read-only cache. Each line is invalid, reserved or valid. A reserved line has been claimed for a block whose data is still on its way from memory. The block takes one lookup address per cycle and answers with one of four results: a true hit, a hit on a reserved line, a miss, or a reservation failure. A reservation failure means the set has no line that may be replaced. A separate fill port marks the arrival of a block. A flush input invalidates every line at once.

A parameter selects the allocation policy. Under allocate-on-miss, a miss claims a line and reserves it, and the later fill turns that line valid. Under allocate-on-fill, a miss leaves the array untouched, and the fill installs the block directly as valid. When a line must be replaced, an invalid way is taken first. Otherwise the valid way with the oldest last-use stamp is taken. The stamp is a free-running cycle count. Three counters report accesses, misses and hits on reserved lines.

Within one cycle the three inputs act in a fixed order: flush first, then fill, then the lookup. A lookup therefore sees the effect of a flush or fill presented in the same cycle.

Top module: `tag_store`

## Requirements
- R1: The line offset is the low log2(LINE_BYTES) address bits. The set index is the next log2(NUM_SETS) bits, and the tag is all bits above those. rsp_blk_addr_o is the looked-up address with the offset bits cleared.
- R2: rsp_valid_o is high in exactly the cycles that follow a cycle with req_i high. After reset, rsp_valid_o and all three counters read zero.
- R3: rsp_status_o encodes the result as 0 = hit on a valid line, 1 = hit on a reserved line, 2 = miss, 3 = reservation failure. A lookup hits when a way of the indexed set is not invalid and its tag matches. rsp_way_o gives the matching way on a hit.
- R4: Under allocate-on-miss, a miss with a replaceable way writes the new tag into that way, reserves it, and reports it on rsp_way_o. A later lookup of the same block returns status 1.
- R5: Under allocate-on-miss, a fill whose block matches a reserved line makes that line valid, so later lookups return status 0. A fill to a block that is not reserved in its set changes nothing: a later lookup of that block still misses.
- R6: Under allocate-on-miss, a lookup returns status 3 when it has no match and every way of the set is reserved. rsp_way_o is then 0, and the reserved lines stay as they are.
- R7: The replacement way is the lowest-numbered invalid way. If no way is invalid, it is the valid way with the oldest last-use stamp, with the lowest index winning a tie. A hit refreshes the stamp of its line, and so does an allocation. On a miss, rsp_way_o reports this way.
- R8: access_cnt_o counts every lookup. miss_cnt_o counts statuses 2 and 3. pend_hit_cnt_o counts status 1. Each counter is updated on the same edge that registers the response.
- R9: flush_i invalidates every line in the array in one cycle. A lookup in the same cycle as the flush returns status 2 with way 0.
- R10: Under allocate-on-fill, a miss changes no line, and statuses 1 and 3 never occur. A fill of a block not present installs it as valid in the replacement way chosen per R7.
- R11: A fill and a lookup in the same cycle act in that order: the lookup sees the line as the fill left it. A flush in the same cycle overrides the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all lines |
| req_i | input | 1 | Lookup strobe |
| req_addr_i | input | ADDR_W | Lookup byte address |
| fill_i | input | 1 | Fill strobe |
| fill_addr_i | input | ADDR_W | Byte address of the arriving block |
| rsp_valid_o | output | 1 | Response for the previous cycle's lookup |
| rsp_status_o | output | 2 | Lookup result code |
| rsp_way_o | output | WAY_W | Matching way, or the replacement way on a miss |
| rsp_blk_addr_o | output | ADDR_W | Block address of the lookup |
| access_cnt_o | output | CNT_W | Lookup count |
| miss_cnt_o | output | CNT_W | Miss and failure count |
| pend_hit_cnt_o | output | CNT_W | Hits on reserved lines |

## Verification
Every result of a lookup, including the three counters, is registered on the first rising edge after the request. A fill or flush changes the array on that same edge. The bench changes its inputs on a falling edge and compares all outputs on the next falling edge, which is half a period after that registering edge. A bench-side model of both policies predicts each response. The model's line state is advanced in the same order the block uses: flush, then fill, then lookup.

// File: rtl/tag_store_pkg.sv
package tag_store_pkg;
  localparam logic [1:0] LN_INV = 2'd0;
  localparam logic [1:0] LN_RSV = 2'd1;
  localparam logic [1:0] LN_VLD = 2'd2;

  localparam logic [1:0] RES_HIT     = 2'd0;
  localparam logic [1:0] RES_HIT_RSV = 2'd1;
  localparam logic [1:0] RES_MISS    = 2'd2;
  localparam logic [1:0] RES_FAIL    = 2'd3;
endpackage

// File: rtl/ts_addr_split.sv
module ts_addr_split #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 5,
  parameter int IDX_W  = 3,
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
  input  logic [LINE_W-1:0] line_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  assign idx_o = line_i[IDX_W-1:0];
  assign tag_o = line_i[LINE_W-1:IDX_W];
endmodule

// File: rtl/ts_way_sel.sv
module ts_way_sel
  import tag_store_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int TAG_W    = 20,
  parameter int TIME_W   = 32,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic [NUM_WAYS-1:0][1:0]        st_i,
  input  logic [NUM_WAYS-1:0][TAG_W-1:0]  tag_i,
  input  logic [NUM_WAYS-1:0][TIME_W-1:0] last_i,
  input  logic [TAG_W-1:0]                key_i,
  output logic                            hit_o,
  output logic [WAY_W-1:0]                hit_way_o,
  output logic [1:0]                      hit_st_o,
  output logic                            vic_ok_o,
  output logic [WAY_W-1:0]                vic_way_o
);
  logic              inv_found, vld_found;
  logic [WAY_W-1:0]  inv_way, vld_way;
  logic [TIME_W-1:0] oldest;

  // descending scan: lowest matching way wins
  always_comb begin
    hit_o     = 1'b0;
    hit_way_o = '0;
    hit_st_o  = LN_INV;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (st_i[w] != LN_INV && tag_i[w] == key_i) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
        hit_st_o  = st_i[w];
      end
    end
  end

  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (!inv_found && st_i[w] == LN_INV) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(w);
      end
    end
  end

  // reserved ways are never candidates
  always_comb begin
    vld_found = 1'b0;
    vld_way   = '0;
    oldest    = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (st_i[w] == LN_VLD && (!vld_found || last_i[w] < oldest)) begin
        vld_found = 1'b1;
        vld_way   = WAY_W'(w);
        oldest    = last_i[w];
      end
    end
  end

  assign vic_ok_o  = inv_found | vld_found;
  assign vic_way_o = inv_found ? inv_way : vld_way;
endmodule

// File: rtl/ts_counters.sv
module ts_counters #(
  parameter int CNT_W = 32,
  parameter int NUM   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM-1:0]             inc_i,
  output logic [NUM-1:0][CNT_W-1:0]  cnt_o
);
  for (genvar i = 0; i < NUM; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (inc_i[i]) cnt_q <= cnt_q + CNT_W'(1);
    end
    assign cnt_o[i] = cnt_q;
  end
endmodule

// File: rtl/tag_store.sv
module tag_store
  import tag_store_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int LINE_BYTES    = 32,
  parameter int NUM_SETS      = 8,
  parameter int NUM_WAYS      = 4,
  parameter int TIME_W        = 32,
  parameter int CNT_W         = 32,
  parameter bit ALLOC_ON_MISS = 1'b1,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(NUM_SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int WAY_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              fill_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o,
  output logic [WAY_W-1:0]  rsp_way_o,
  output logic [ADDR_W-1:0] rsp_blk_addr_o,
  output logic [CNT_W-1:0]  access_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o,
  output logic [CNT_W-1:0]  pend_hit_cnt_o
);
  typedef logic [NUM_WAYS-1:0][1:0]        set_st_t;
  typedef logic [NUM_WAYS-1:0][TAG_W-1:0]  set_tag_t;
  typedef logic [NUM_WAYS-1:0][TIME_W-1:0] set_last_t;

  set_st_t   st_q   [NUM_SETS], st_mid   [NUM_SETS], st_nxt   [NUM_SETS];
  set_tag_t  tag_q  [NUM_SETS], tag_mid  [NUM_SETS], tag_nxt  [NUM_SETS];
  set_last_t last_q [NUM_SETS], last_mid [NUM_SETS], last_nxt [NUM_SETS];
  logic [TIME_W-1:0] now_q;

  logic              unused_off;
  assign unused_off = ^{req_addr_i[OFF_W-1:0], fill_addr_i[OFF_W-1:0]};

  // address split
  logic [IDX_W-1:0] r_idx, f_idx;
  logic [TAG_W-1:0] r_tag, f_tag;

  ts_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split_req (
    .line_i(req_addr_i[ADDR_W-1:OFF_W]), .idx_o(r_idx), .tag_o(r_tag)
  );
  ts_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split_fill (
    .line_i(fill_addr_i[ADDR_W-1:OFF_W]), .idx_o(f_idx), .tag_o(f_tag)
  );

  // fill stage: looks at registered state
  logic             f_hit, f_vic_ok;
  logic [WAY_W-1:0] f_hit_way, f_vic_way;
  logic [1:0]       f_hit_st;

  ts_way_sel #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .TIME_W(TIME_W)) u_sel_fill (
    .st_i(st_q[f_idx]), .tag_i(tag_q[f_idx]), .last_i(last_q[f_idx]), .key_i(f_tag),
    .hit_o(f_hit), .hit_way_o(f_hit_way), .hit_st_o(f_hit_st),
    .vic_ok_o(f_vic_ok), .vic_way_o(f_vic_way)
  );

  logic             fill_set_vld, fill_set_tag;
  logic [WAY_W-1:0] fill_way;

  if (ALLOC_ON_MISS) begin : g_fill_promote
    logic unused_fvic;
    assign unused_fvic  = f_vic_ok ^ (^f_vic_way);
    assign fill_set_vld = f_hit && (f_hit_st == LN_RSV);
    assign fill_set_tag = 1'b0;
    assign fill_way     = f_hit_way;
  end else begin : g_fill_install
    logic unused_fhit;
    assign unused_fhit  = (^f_hit_st) ^ (^f_hit_way);
    assign fill_set_vld = !f_hit && f_vic_ok;
    assign fill_set_tag = fill_set_vld;
    assign fill_way     = f_vic_way;
  end

  // flush beats fill
  always_comb begin
    st_mid   = st_q;
    tag_mid  = tag_q;
    last_mid = last_q;
    if (flush_i) begin
      for (int s = 0; s < NUM_SETS; s++) st_mid[s] = '0;
    end else if (fill_i) begin
      if (fill_set_vld) st_mid[f_idx][fill_way] = LN_VLD;
      if (fill_set_tag) begin
        tag_mid[f_idx][fill_way]  = f_tag;
        last_mid[f_idx][fill_way] = now_q;
      end
    end
  end

  // lookup stage: sees post-flush/fill state
  logic             r_hit, r_vic_ok;
  logic [WAY_W-1:0] r_hit_way, r_vic_way;
  logic [1:0]       r_hit_st;

  ts_way_sel #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .TIME_W(TIME_W)) u_sel_req (
    .st_i(st_mid[r_idx]), .tag_i(tag_mid[r_idx]), .last_i(last_mid[r_idx]), .key_i(r_tag),
    .hit_o(r_hit), .hit_way_o(r_hit_way), .hit_st_o(r_hit_st),
    .vic_ok_o(r_vic_ok), .vic_way_o(r_vic_way)
  );

  logic [1:0]       res;
  logic [WAY_W-1:0] res_way;

  always_comb begin
    res     = RES_FAIL;
    res_way = '0;
    if (r_hit) begin
      res     = (r_hit_st == LN_VLD) ? RES_HIT : RES_HIT_RSV;
      res_way = r_hit_way;
    end else if (r_vic_ok) begin
      res     = RES_MISS;
      res_way = r_vic_way;
    end
  end

  always_comb begin
    st_nxt   = st_mid;
    tag_nxt  = tag_mid;
    last_nxt = last_mid;
    if (req_i) begin
      if (r_hit) begin
        last_nxt[r_idx][r_hit_way] = now_q;
      end else if (r_vic_ok && ALLOC_ON_MISS) begin
        st_nxt[r_idx][r_vic_way]   = LN_RSV;
        tag_nxt[r_idx][r_vic_way]  = r_tag;
        last_nxt[r_idx][r_vic_way] = now_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        st_q[s]   <= '0;
        tag_q[s]  <= '0;
        last_q[s] <= '0;
      end
      now_q <= '0;
    end else begin
      st_q   <= st_nxt;
      tag_q  <= tag_nxt;
      last_q <= last_nxt;
      now_q  <= now_q + TIME_W'(1);
    end
  end

  // response register
  logic              rsp_valid_q;
  logic [1:0]        rsp_status_q;
  logic [WAY_W-1:0]  rsp_way_q;
  logic [ADDR_W-1:0] rsp_blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= RES_HIT;
      rsp_way_q    <= '0;
      rsp_blk_q    <= '0;
    end else begin
      rsp_valid_q <= req_i;
      if (req_i) begin
        rsp_status_q <= res;
        rsp_way_q    <= res_way;
        rsp_blk_q    <= {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end
    end
  end

  assign rsp_valid_o    = rsp_valid_q;
  assign rsp_status_o   = rsp_status_q;
  assign rsp_way_o      = rsp_way_q;
  assign rsp_blk_addr_o = rsp_blk_q;

  // counters: [0] access, [1] miss, [2] pending hit
  logic [2:0]            cnt_inc;
  logic [2:0][CNT_W-1:0] cnt_val;

  assign cnt_inc = {req_i && (res == RES_HIT_RSV), req_i && res[1], req_i};

  ts_counters #(.CNT_W(CNT_W), .NUM(3)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(cnt_inc), .cnt_o(cnt_val)
  );

  assign access_cnt_o   = cnt_val[0];
  assign miss_cnt_o     = cnt_val[1];
  assign pend_hit_cnt_o = cnt_val[2];

  // assertions
  a_r2_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  a_r2_no_rsp_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);
  a_r8_access_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> access_cnt_o == $past(access_cnt_o) + CNT_W'(1));
  a_r8_miss_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o[1]) |-> miss_cnt_o == $past(miss_cnt_o) + CNT_W'(1));
  a_r8_pend_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o == RES_HIT_RSV) |->
      pend_hit_cnt_o == $past(pend_hit_cnt_o) + CNT_W'(1));
  a_r9_flush_then_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && req_i) |=> rsp_status_o == RES_MISS && rsp_way_o == '0);

  if (!ALLOC_ON_MISS) begin : g_chk_on_fill
    a_r10_no_reserve: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o |-> (rsp_status_o == RES_HIT || rsp_status_o == RES_MISS));
  end
endmodule

// File: tb/sim_tag_store.sv
`timescale 1ns/1ps
module sim_tag_store;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, req = 1'b0, fill = 1'b0;
  logic [AW-1:0] req_addr = '0, fill_addr = '0;

  logic [1:0]        o_vld;
  logic [1:0][1:0]   o_st;
  logic [1:0][0:0]   o_way;
  logic [1:0][AW-1:0] o_blk;
  logic [1:0][15:0]  o_acc, o_miss, o_pend;

  always #2.5 clk = ~clk;

  tag_store #(.ADDR_W(AW), .LINE_BYTES(16), .NUM_SETS(4), .NUM_WAYS(2),
              .TIME_W(16), .CNT_W(16), .ALLOC_ON_MISS(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .req_i(req), .req_addr_i(req_addr),
    .fill_i(fill), .fill_addr_i(fill_addr), .rsp_valid_o(o_vld[0]), .rsp_status_o(o_st[0]),
    .rsp_way_o(o_way[0]), .rsp_blk_addr_o(o_blk[0]), .access_cnt_o(o_acc[0]),
    .miss_cnt_o(o_miss[0]), .pend_hit_cnt_o(o_pend[0])
  );

  tag_store #(.ADDR_W(AW), .LINE_BYTES(16), .NUM_SETS(4), .NUM_WAYS(2),
              .TIME_W(16), .CNT_W(16), .ALLOC_ON_MISS(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .req_i(req), .req_addr_i(req_addr),
    .fill_i(fill), .fill_addr_i(fill_addr), .rsp_valid_o(o_vld[1]), .rsp_status_o(o_st[1]),
    .rsp_way_o(o_way[1]), .rsp_blk_addr_o(o_blk[1]), .access_cnt_o(o_acc[1]),
    .miss_cnt_o(o_miss[1]), .pend_hit_cnt_o(o_pend[1])
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // model: p=0 allocate-on-miss (u0), p=1 allocate-on-fill (u1); state 0 inv, 1 rsv, 2 vld
  int m_st [2][4][2];
  int m_tag[2][4][2];
  int m_last[2][4][2];
  int m_acc[2], m_miss[2], m_pend[2];
  int e_st[2], e_way[2];
  int stamp = 0;

  task automatic chk(input string r, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic int mfind(int p, int s, int t);
    for (int w = 0; w < 2; w++)
      if (m_st[p][s][w] != 0 && m_tag[p][s][w] == t) return w;
    return -1;
  endfunction

  function automatic int mvic(int p, int s);
    int best;
    best = -1;
    for (int w = 0; w < 2; w++) if (m_st[p][s][w] == 0) return w;
    for (int w = 0; w < 2; w++)
      if (m_st[p][s][w] == 2 && (best < 0 || m_last[p][s][w] < m_last[p][s][best])) best = w;
    return best;
  endfunction

  task automatic model(input bit rq, input int a, input bit fl, input int fa, input bit fz);
    int s, t, w, v;
    for (int p = 0; p < 2; p++) begin
      if (fz) begin
        for (int i = 0; i < 4; i++) for (int j = 0; j < 2; j++) m_st[p][i][j] = 0;
      end else if (fl) begin
        s = (fa >> 4) & 3; t = fa >> 6; w = mfind(p, s, t);
        if (p == 0) begin
          if (w >= 0 && m_st[p][s][w] == 1) m_st[p][s][w] = 2;
        end else if (w < 0) begin
          v = mvic(p, s);
          if (v >= 0) begin m_st[p][s][v] = 2; m_tag[p][s][v] = t; m_last[p][s][v] = stamp; end
        end
      end
      if (rq) begin
        s = (a >> 4) & 3; t = a >> 6; w = mfind(p, s, t);
        m_acc[p]++;
        if (w >= 0) begin
          e_st[p] = (m_st[p][s][w] == 2) ? 0 : 1;
          if (e_st[p] == 1) m_pend[p]++;
          e_way[p] = w;
          m_last[p][s][w] = stamp;
        end else begin
          v = mvic(p, s);
          m_miss[p]++;
          if (v < 0) begin e_st[p] = 3; e_way[p] = 0; end
          else begin
            e_st[p] = 2; e_way[p] = v;
            if (p == 0) begin m_st[p][s][v] = 1; m_tag[p][s][v] = t; m_last[p][s][v] = stamp; end
          end
        end
      end
    end
    stamp++;
  endtask

  task automatic step(input string r, input bit rq, input int a, input bit fl,
                      input int fa, input bit fz);
    req = rq; req_addr = a[AW-1:0]; fill = fl; fill_addr = fa[AW-1:0]; flush = fz;
    model(rq, a, fl, fa, fz);
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      chk(r, $sformatf("u%0d valid (R2)", p), int'(o_vld[p]), int'(rq));
      if (rq) begin
        chk(r, $sformatf("u%0d status", p), int'(o_st[p]), e_st[p]);
        chk(r, $sformatf("u%0d way", p), int'(o_way[p]), e_way[p]);
        chk(r, $sformatf("u%0d blk (R1)", p), int'(o_blk[p]), a & 'hFF0);
      end
      chk(r, $sformatf("u%0d access cnt (R8)", p), int'(o_acc[p]), m_acc[p]);
      chk(r, $sformatf("u%0d miss cnt (R8)", p), int'(o_miss[p]), m_miss[p]);
      chk(r, $sformatf("u%0d pend cnt (R8)", p), int'(o_pend[p]), m_pend[p]);
    end
    req = 1'b0; fill = 1'b0; flush = 1'b0;
  endtask

  function automatic int mk(int t, int s);
    return (t << 6) | (s << 4) | 3;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    int r, a, fa;
    for (int p = 0; p < 2; p++) begin
      m_acc[p] = 0; m_miss[p] = 0; m_pend[p] = 0;
      for (int i = 0; i < 4; i++) for (int j = 0; j < 2; j++) begin
        m_st[p][i][j] = 0; m_tag[p][i][j] = 0; m_last[p][i][j] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin
      chk("R2", $sformatf("u%0d reset valid", p), int'(o_vld[p]), 0);
      chk("R8", $sformatf("u%0d reset access", p), int'(o_acc[p]), 0);
      chk("R8", $sformatf("u%0d reset miss", p), int'(o_miss[p]), 0);
      chk("R8", $sformatf("u%0d reset pend", p), int'(o_pend[p]), 0);
    end

    // R4: miss reserves, second lookup hits reserved
    step("R4", 1, mk(1, 0), 0, 0, 0);
    step("R4", 1, mk(1, 0), 0, 0, 0);
    chk("R4", "u0 hit on reserved", int'(o_st[0]), 1);
    // R5: fill promotes; stray fill ignored
    step("R5", 0, 0, 1, mk(1, 0), 0);
    step("R5", 1, mk(1, 0), 0, 0, 0);
    chk("R5", "u0 hit after fill", int'(o_st[0]), 0);
    step("R5", 0, 0, 1, mk(2, 2), 0);
    step("R5", 1, mk(2, 2), 0, 0, 0);
    chk("R5", "u0 stray fill ignored", int'(o_st[0]), 2);
    chk("R10", "u1 fill installs", int'(o_st[1]), 0);
    // R6: all ways reserved
    step("R6", 1, mk(1, 3), 0, 0, 0);
    step("R6", 1, mk(2, 3), 0, 0, 0);
    step("R6", 1, mk(3, 3), 0, 0, 0);
    chk("R6", "u0 fail", int'(o_st[0]), 3);
    chk("R10", "u1 no fail", int'(o_st[1]), 2);
    step("R6", 1, mk(1, 3), 0, 0, 0);
    chk("R6", "u0 reserved kept", int'(o_st[0]), 1);
    // R7: LRU victim after refresh
    step("R7", 1, mk(1, 1), 0, 0, 0);
    step("R7", 0, 0, 1, mk(1, 1), 0);
    step("R7", 1, mk(2, 1), 0, 0, 0);
    step("R7", 0, 0, 1, mk(2, 1), 0);
    step("R7", 1, mk(1, 1), 0, 0, 0);
    step("R7", 1, mk(3, 1), 0, 0, 0);
    chk("R7", "u0 victim is older way", int'(o_way[0]), 1);
    // R11: same-cycle fill then lookup
    step("R11", 1, mk(4, 2), 0, 0, 0);
    step("R11", 1, mk(4, 2), 1, mk(4, 2), 0);
    chk("R11", "u0 sees fill", int'(o_st[0]), 0);
    chk("R11", "u1 sees fill", int'(o_st[1]), 0);
    // R9: flush with lookup
    step("R9", 1, mk(1, 1), 1, mk(1, 1), 1);
    chk("R9", "u0 flushed miss", int'(o_st[0]), 2);
    step("R9", 1, mk(1, 3), 0, 0, 0);
    chk("R9", "u0 other set flushed", int'(o_st[0]), 2);

    // R1: sweep every block address once
    for (int b = 0; b < 256; b++) step("R1", 1, (b << 4) | (b & 15), 0, 0, 0);

    // R3: pseudo-random mix over a small tag range
    seed = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      r  = int'(seed >> 8);
      a  = (((r >> 2) & 3) << 6) | (((r >> 4) & 3) << 4) | ((r >> 6) & 15);
      fa = (((r >> 12) & 3) << 6) | (((r >> 14) & 3) << 4);
      step("R3", (r & 3) != 0, a, ((r >> 10) & 3) == 0, fa, ((r >> 16) & 63) == 0);
    end
    finish_run();
  end
endmodule